// File: doc/BRIEF.md
# Software-Driven Bus Reset Line with Advisory Hold Timer

This block gives host software direct control over the level of a reset line that runs out to a peripheral bus. A write to the control word sets the line's level on the next clock edge. No sequencing, no qualification and no wait for any other activity is involved. The reset path has no link to the logic that runs bus cycles, so the level may change while such a cycle is in progress.

Each write to the control word also reloads a hold timer. While the timer is counting down, a status flag reports "busy". Software drives the line to its active level, polls the flag until it drops, and then writes the opposite level to release the line. The default hold length is 150 ms at a 50 MHz clock, given as a cycle-count parameter. The flag is only a hint to software: it never blocks or delays a level change.

The register port is a plain single-cycle write strobe and read strobe. There is no stream traffic, so no valid/ready handshake exists and no back-pressure applies: every strobe is accepted in the cycle it is presented. Read data appears one cycle after the read strobe.

Top module: `busrst_level_ctrl`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `bus_rst_lvl` equals parameter `RST_DEFAULT` (default 0), `rst_busy` is 0 and `rd_data` is 0.
- R2: A write with `wr_addr` = 0x0 (the control word) sets `bus_rst_lvl` to `wr_data[0]` at the first clock edge after the strobe. Writing 1 drives the line high; writing 0 drives it low.
- R3: After a control write, `rst_busy` is 1 for exactly `HOLD_CYCLES` consecutive cycles starting with the edge that accepts the write, and is 0 afterwards.
- R4: A control write made while `rst_busy` is 1 restarts the count from the full value, so `rst_busy` stays 1 for `HOLD_CYCLES` cycles measured from the latest write.
- R5: A control write made while `rst_busy` is 1 still updates `bus_rst_lvl` at the next edge. The busy flag never holds back the line.
- R6: A read with `rd_addr` = 0x1 (the status word) returns `rst_busy` in bit 0 and zeros in every other bit, one cycle after `rd_en`. A read changes neither the line level nor the remaining hold time.
- R7: A read with `rd_addr` = 0x0 returns the current line level in bit 0 and zeros above it. A read of any other address returns all zeros.
- R8: A write to any address other than 0x0, including the status word, changes neither `bus_rst_lvl` nor the hold timer.
- R9: A control write that repeats the current level still restarts the hold timer.
- R10: Once the hold count has expired, `rst_busy` stays 0 until the next control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write word address (0x0 = control) |
| wr_data | input | DATA_W | Write data; bit 0 is the line level |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address (0x0 control, 0x1 status) |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |
| bus_rst_lvl | output | 1 | Level driven onto the peripheral reset line |
| rst_busy | output | 1 | Hold timer running (advisory) |

## Verification
The stimulus exercises the hold timer with four patterns: a single write; a second write halfway through the count; a second write whose value equals the current level; and reads made during the count. These patterns separate a timer that reloads on every control write from one that ignores writes while running, reloads only when the level changes, or is disturbed by reads. Level changes made during the busy window show whether the flag gates the output. Writes to the status address and to an unmapped address, issued while the flag is idle, show whether address decoding leaks into the line or the timer. Counting the busy cycles exactly against a small hold parameter pins down off-by-one errors at both ends of the window.

// File: rtl/busrst_pkg.sv
package busrst_pkg;

  localparam int unsigned CTRL_WORD = 0;
  localparam int unsigned STAT_WORD = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e word_decode(input logic [31:0] addr);
    if (addr == 32'(CTRL_WORD)) return SEL_CTRL;
    if (addr == 32'(STAT_WORD)) return SEL_STAT;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/busrst_addr_dec.sv
module busrst_addr_dec
  import busrst_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = word_decode(32'(addr));
  end

endmodule

// File: rtl/busrst_level_reg.sv
module busrst_level_reg #(
  parameter logic RST_DEFAULT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic new_lvl,
  output logic lvl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl <= RST_DEFAULT;
    else if (load) lvl <= new_lvl;
  end

  // R2 / R5: a load lands on the very next edge, whatever else is going on
  p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lvl == $past(new_lvl)));

  // R8: without a load the level never moves
  p_hold_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lvl));

endmodule

// File: rtl/busrst_hold_timer.sv
module busrst_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 7_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic busy
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (restart)         remain <= CNT_FULL;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  // R4 / R9: every restart reloads the full count
  p_reload_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (remain == CNT_FULL));

  // R3: a running count goes down by exactly one per cycle
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && remain != '0) |=> (remain == $past(remain) - 1'b1));

  // R10: an expired count stays expired until restarted
  p_stay_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && remain == '0) |=> (remain == '0));

endmodule

// File: rtl/busrst_rd_port.sv
module busrst_rd_port
  import busrst_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          rd_sel,
  input  logic              lvl,
  input  logic              busy,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word_ctrl;
  logic [DATA_W-1:0] word_stat;
  logic [DATA_W-1:0] word_mux;

  // bit 0 carries the flag, every bit above is tied low
  for (genvar b = 0; b < DATA_W; b++) begin : g_word
    if (b == 0) begin : g_lsb
      assign word_ctrl[b] = lvl;
      assign word_stat[b] = busy;
    end else begin : g_pad
      assign word_ctrl[b] = 1'b0;
      assign word_stat[b] = 1'b0;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: word_mux = word_ctrl;
      SEL_STAT: word_mux = word_stat;
      default:  word_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word_mux;
  end

  // R6: status read reflects the busy flag sampled at the strobe
  p_stat_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_STAT) |=> (rd_data == DATA_W'($past(busy))));

  // R7: unmapped reads return zero
  p_none_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_NONE) |=> (rd_data == '0));

endmodule

// File: rtl/busrst_level_ctrl.sv
module busrst_level_ctrl
  import busrst_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HOLD_CYCLES = 7_500_000,
  parameter logic        RST_DEFAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_rst_lvl,
  output logic              rst_busy
);

  reg_sel_e wr_sel;
  reg_sel_e rd_sel;
  logic     ctrl_wr;
  logic     unused_wr_hi;

  busrst_addr_dec #(.ADDR_W(ADDR_W)) u_wr_dec (
    .addr (wr_addr),
    .sel  (wr_sel)
  );

  busrst_addr_dec #(.ADDR_W(ADDR_W)) u_rd_dec (
    .addr (rd_addr),
    .sel  (rd_sel)
  );

  assign ctrl_wr      = wr_en && (wr_sel == SEL_CTRL);
  assign unused_wr_hi = ^wr_data;

  busrst_level_reg #(.RST_DEFAULT(RST_DEFAULT)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctrl_wr),
    .new_lvl (wr_data[0]),
    .lvl     (bus_rst_lvl)
  );

  busrst_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr),
    .busy    (rst_busy)
  );

  busrst_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .lvl     (bus_rst_lvl),
    .busy    (rst_busy),
    .rd_data (rd_data)
  );

  // R3 / R4: a control write always leaves the flag raised on the next cycle
  p_busy_after_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(CTRL_WORD)) |=> rst_busy);

  // R5: a busy flag never stops the line from following a control write
  p_no_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && wr_en && wr_addr == ADDR_W'(CTRL_WORD))
      |=> (bus_rst_lvl == $past(wr_data[0])));

  // R8: a write elsewhere cannot raise an idle flag
  p_stray_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_busy && wr_en && wr_addr != ADDR_W'(CTRL_WORD)) |=> !rst_busy);

endmodule

// File: tb/busrst_level_ctrl_tb.sv
module busrst_level_ctrl_tb;

  localparam int unsigned AW   = 4;
  localparam int unsigned DW   = 8;
  localparam int unsigned HOLD = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          bus_rst_lvl;
  logic          rst_busy;

  int vec = 0;
  int err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busrst_level_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .HOLD_CYCLES(HOLD), .RST_DEFAULT(1'b0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_rst_lvl(bus_rst_lvl), .rst_busy(rst_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // counts negedge samples with the flag high, starting at the current one
  task automatic busy_len(output int n);
    n = 0;
    while (rst_busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 level", int'(bus_rst_lvl), 0);
    chk("R1 busy", int'(rst_busy), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    do_rd(4'h1);
    chk("R1 status word", int'(rd_data), 0);
  endtask

  task automatic t_single;
    int n;
    do_wr(4'h0, 8'h01);
    chk("R2 drive high", int'(bus_rst_lvl), 1);
    busy_len(n);
    chk("R3 busy length", n, HOLD);
    repeat (8) @(negedge clk);
    chk("R10 stays idle", int'(rst_busy), 0);
    do_wr(4'h0, 8'hFE);
    chk("R2 drive low", int'(bus_rst_lvl), 0);
    busy_len(n);
  endtask

  task automatic t_restart;
    int n;
    do_wr(4'h0, 8'h01);
    repeat (9) @(negedge clk);
    do_wr(4'h0, 8'h01);
    chk("R9 same value keeps level", int'(bus_rst_lvl), 1);
    busy_len(n);
    chk("R4 R9 restart length", n, HOLD);
  endtask

  task automatic t_nogate;
    int n;
    do_wr(4'h0, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 busy before", int'(rst_busy), 1);
    do_wr(4'h0, 8'h00);
    chk("R5 level follows during busy", int'(bus_rst_lvl), 0);
    busy_len(n);
  endtask

  task automatic t_reads;
    int n;
    do_wr(4'h0, 8'h01);
    do_rd(4'h1);
    chk("R6 status busy", int'(rd_data), 1);
    do_rd(4'h0);
    chk("R7 control word", int'(rd_data), 1);
    chk("R6 read keeps level", int'(bus_rst_lvl), 1);
    busy_len(n);
    chk("R6 reads keep hold time", n, HOLD - 4);
    do_rd(4'h1);
    chk("R6 status idle", int'(rd_data), 0);
    do_rd(4'h7);
    chk("R7 unmapped read", int'(rd_data), 0);
  endtask

  task automatic t_stray;
    do_wr(4'h1, 8'h00);
    chk("R8 status write level", int'(bus_rst_lvl), 1);
    chk("R8 status write busy", int'(rst_busy), 0);
    do_wr(4'h5, 8'h00);
    chk("R8 unmapped write level", int'(bus_rst_lvl), 1);
    chk("R8 unmapped write busy", int'(rst_busy), 0);
    do_rd(4'h0);
    chk("R8 control word intact", int'(rd_data), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_restart();
    t_nogate();
    t_reads();
    t_stray();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vec++;
      err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

endmodule